// File: doc/BRIEF.md
# Clock Mode and Oscillator-Status Controller

This block keeps track of which clock mode a chip's clock unit is in and turns a few register-style control bits into the select lines that steer the clock muxes. There are three modes. In the default mode the PLL drives the bus and takes its reference from the internal generator. In the external-engaged mode the PLL still drives the bus but takes its reference from the external oscillator. In the bypass mode the bus runs straight from the oscillator, and the PLL reference stays on the oscillator.

The block also holds an oscillator-up flag. The flag is built from good reports that a VCO-clocked qualifier delivers on tick strobes. Because that qualifier needs a running VCO, the flag is only meaningful while the PLL is locked. It drops in the same cycle that lock goes low. Each time the flag falls while an external mode is active, a one-cycle status-lost pulse is raised, so software can re-set-up any peripheral that runs from the oscillator. The analog PLL, the oscillator and glitch-free mux switching are outside this block.

Top module: `clk_mode_top`

## Requirements
- R1: After reset the mode is default (mode code 0), busSelPll=1, refSelOsc=0, qualEn=0, oscUp=0, statusLost=0 and refDivOut=0.
- R2: Mode codes are 0 = internal-reference engaged, 1 = external-reference engaged and 2 = bypassed on the oscillator. From mode 0, oscEnBit=1 sampled at an edge gives mode 1 after that edge. Outputs follow the mode as busSelPll = (mode != 2), refSelOsc = (mode != 0) and qualEn = (mode != 0).
- R3: The oscillator flag (oscUp) becomes 1 after the edge that samples the 4th consecutive qualTick with oscGood=1. Every one of those ticks must be sampled while the mode is external, pllLock=1 and oscEnBit=1. Ticks sampled in mode 0 do not count.
- R4: A qualTick with oscGood=0 restarts the consecutive-good count from zero.
- R5: While pllLock=0, oscUp reads 0 in the same cycle, without waiting for a clock edge. An edge that samples pllLock=0 clears the stored flag and the good count.
- R6: In mode 1, pllSelBit=0 sampled together with oscUp=1 moves the mode to 2 after that edge, and busSelPll becomes 0.
- R7: In mode 1, pllSelBit=0 sampled while oscUp=0 is ignored: the mode stays 1 and busSelPll stays 1.
- R8: In mode 2, pllSelBit=1 sampled at an edge returns the mode to 1.
- R9: oscEnBit=0 sampled at an edge returns the mode to 0 after that edge and clears the oscillator flag.
- R10: statusLost is high for exactly the one cycle after an edge at which a stored oscUp of 1 is cleared (by lock loss or oscillator disable). It is 0 at all other times.
- R11: In mode 0, refDivOut takes the value of refDiv one edge later. In modes 1 and 2, refDivOut holds its value and ignores refDiv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pllSelBit | input | 1 | Control bit: 1 keeps the bus on the PLL, 0 asks for the oscillator |
| oscEnBit | input | 1 | Control bit: oscillator enable |
| refDiv | input | 4 | Reference divider setting |
| pllLock | input | 1 | PLL lock indication |
| qualTick | input | 1 | One-cycle strobe marking a qualifier report |
| oscGood | input | 1 | Qualifier verdict, valid when qualTick is 1 |
| modeOut | output | 2 | Current mode code |
| busSelPll | output | 1 | Bus mux select: 1 PLL, 0 oscillator |
| refSelOsc | output | 1 | PLL reference mux select: 1 oscillator, 0 internal |
| qualEn | output | 1 | Enables the oscillator qualifier |
| oscUp | output | 1 | Oscillator-qualified flag |
| statusLost | output | 1 | One-cycle pulse when the oscillator flag is lost |
| refDivOut | output | 4 | Divider value applied to the PLL reference |

## Verification
The assertions assume that pllLock, qualTick and oscGood are already synchronous to clk. They also assume that qualTick is a single-cycle strobe and that oscGood is only looked at when qualTick is 1. The bench drives every input from a single process, one clock after each edge, so all inputs are clean and synchronous. Its random phase holds oscEnBit and pllLock mostly high so that the qualification count can complete. It still drops each of them now and then, and it toggles pllSelBit so that both legal and refused bypass requests occur.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

  typedef enum logic [1:0] {
    MODE_INT_PLL    = 2'd0,
    MODE_EXT_PLL    = 2'd1,
    MODE_EXT_BYPASS = 2'd2
  } clkMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic qualRun;    // qualifier result may be counted
    logic flagClear;  // drop count and stored flag
    logic divLoad;    // divider may be updated
  } ctrlStrobe_t;

endpackage

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pllSelBit,
  input  logic        oscEnBit,
  input  logic        pllLock,
  input  logic        oscUpGated,
  output clkMode_e    modeQ,
  output ctrlStrobe_t strobe
);

  clkMode_e modeNext;

  always_comb begin
    modeNext = modeQ;
    if (!oscEnBit) begin
      modeNext = MODE_INT_PLL;
    end else begin
      case (modeQ)
        MODE_INT_PLL:    modeNext = MODE_EXT_PLL;
        MODE_EXT_PLL:    if (!pllSelBit && oscUpGated) modeNext = MODE_EXT_BYPASS;
        MODE_EXT_BYPASS: if (pllSelBit) modeNext = MODE_EXT_PLL;
        default:         modeNext = MODE_INT_PLL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_INT_PLL;
    else       modeQ <= modeNext;
  end

  always_comb begin
    strobe.qualRun   = (modeQ != MODE_INT_PLL) && pllLock && oscEnBit;
    strobe.flagClear = !strobe.qualRun;
    strobe.divLoad   = (modeQ == MODE_INT_PLL);
  end

  AST_BYPASS_NEEDS_UP: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_EXT_BYPASS && $past(modeQ) != MODE_EXT_BYPASS) |-> $past(oscUpGated)); // R6
  AST_BYPASS_REFUSED: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_EXT_PLL && !oscUpGated && oscEnBit) |=> (modeQ != MODE_EXT_BYPASS)); // R7
  AST_DISABLE_TO_INT: assert property (@(posedge clk) disable iff (!rstN)
    !oscEnBit |=> (modeQ == MODE_INT_PLL)); // R9
  AST_BYPASS_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_EXT_BYPASS && pllSelBit && oscEnBit) |=> (modeQ == MODE_EXT_PLL)); // R8

endmodule

// File: rtl/clk_mode_dp.sv
module clk_mode_dp
  import clk_mode_pkg::*;
#(
  parameter int GOOD_TICKS = 4,
  parameter int DIV_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic              qualTick,
  input  logic              oscGood,
  input  logic [DIV_W-1:0]  refDiv,
  output logic              oscUpReg,
  output logic              lostPulse,
  output logic [DIV_W-1:0]  refDivReg
);

  localparam int CNT_W = $clog2(GOOD_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(GOOD_TICKS);

  logic [CNT_W-1:0] goodCnt;
  logic [CNT_W-1:0] cntInc;

  assign cntInc = (goodCnt == CNT_MAX) ? goodCnt : goodCnt + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      goodCnt  <= '0;
      oscUpReg <= 1'b0;
    end else if (strobe.flagClear) begin
      goodCnt  <= '0;
      oscUpReg <= 1'b0;
    end else if (strobe.qualRun && qualTick) begin
      if (oscGood) begin
        goodCnt <= cntInc;
        if (cntInc == CNT_MAX) oscUpReg <= 1'b1;
      end else begin
        goodCnt <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lostPulse <= 1'b0;
    else       lostPulse <= oscUpReg && strobe.flagClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              refDivReg <= '0;
    else if (strobe.divLoad) refDivReg <= refDiv;
  end

  AST_UP_NEEDS_GOOD_TICK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oscUpReg) |-> $past(qualTick && oscGood && strobe.qualRun)); // R3
  AST_BAD_TICK_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.qualRun && qualTick && !oscGood && !oscUpReg) |=> !oscUpReg); // R4
  AST_CLEAR_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    strobe.flagClear |=> !oscUpReg); // R5
  AST_LOST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    lostPulse |=> !lostPulse); // R10
  AST_LOST_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    lostPulse |-> ($past(oscUpReg) && !oscUpReg)); // R10
  AST_DIV_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.divLoad |=> $stable(refDivReg)); // R11

endmodule

// File: rtl/clk_mode_top.sv
module clk_mode_top
  import clk_mode_pkg::*;
#(
  parameter int GOOD_TICKS = 4,
  parameter int DIV_W      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pllSelBit,
  input  logic             oscEnBit,
  input  logic [DIV_W-1:0] refDiv,
  input  logic             pllLock,
  input  logic             qualTick,
  input  logic             oscGood,
  output logic [1:0]       modeOut,
  output logic             busSelPll,
  output logic             refSelOsc,
  output logic             qualEn,
  output logic             oscUp,
  output logic             statusLost,
  output logic [DIV_W-1:0] refDivOut
);

  clkMode_e    modeQ;
  ctrlStrobe_t strobe;
  logic        oscUpReg;

  // flag is only meaningful while the VCO-clocked qualifier runs
  assign oscUp = oscUpReg & pllLock;

  clk_mode_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .pllSelBit  (pllSelBit),
    .oscEnBit   (oscEnBit),
    .pllLock    (pllLock),
    .oscUpGated (oscUp),
    .modeQ      (modeQ),
    .strobe     (strobe)
  );

  clk_mode_dp #(
    .GOOD_TICKS (GOOD_TICKS),
    .DIV_W      (DIV_W)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .qualTick  (qualTick),
    .oscGood   (oscGood),
    .refDiv    (refDiv),
    .oscUpReg  (oscUpReg),
    .lostPulse (statusLost),
    .refDivReg (refDivOut)
  );

  assign modeOut   = modeQ;
  assign busSelPll = (modeQ != MODE_EXT_BYPASS);
  assign refSelOsc = (modeQ != MODE_INT_PLL);
  assign qualEn    = (modeQ != MODE_INT_PLL);

endmodule

// File: tb/sim_clk_mode_top.sv
module sim_clk_mode_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pllSelBit = 1'b1;
  logic       oscEnBit = 1'b0;
  logic [3:0] refDiv = 4'd0;
  logic       pllLock = 1'b0;
  logic       qualTick = 1'b0;
  logic       oscGood = 1'b0;
  logic [1:0] modeOut;
  logic       busSelPll, refSelOsc, qualEn, oscUp, statusLost;
  logic [3:0] refDivOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  int         mMode = 0;
  int         mCnt = 0;
  bit         mUp = 1'b0;
  bit         mLost = 1'b0;
  logic [3:0] mDiv = 4'd0;

  always #2 clk = ~clk;

  clk_mode_top u0 (
    .clk(clk), .rstN(rstN), .pllSelBit(pllSelBit), .oscEnBit(oscEnBit),
    .refDiv(refDiv), .pllLock(pllLock), .qualTick(qualTick), .oscGood(oscGood),
    .modeOut(modeOut), .busSelPll(busSelPll), .refSelOsc(refSelOsc),
    .qualEn(qualEn), .oscUp(oscUp), .statusLost(statusLost), .refDivOut(refDivOut)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int expBusPll(int m);  return (m != 2) ? 1 : 0; endfunction
  function automatic int expRefOsc(int m);  return (m != 0) ? 1 : 0; endfunction
  function automatic int expUp();           return (mUp && pllLock) ? 1 : 0; endfunction

  task automatic checkAll(string tag);
    chk(tag, "mode", int'(modeOut), mMode);
    chk(tag, "busSelPll", int'(busSelPll), expBusPll(mMode));
    chk(tag, "refSelOsc", int'(refSelOsc), expRefOsc(mMode));
    chk(tag, "qualEn", int'(qualEn), expRefOsc(mMode));
    chk(tag, "oscUp", int'(oscUp), expUp());
    chk(tag, "statusLost", int'(statusLost), int'(mLost));
    chk(tag, "refDivOut", int'(refDivOut), int'(mDiv));
  endtask

  // model of one clock edge, using input values present before the edge
  task automatic modelEdge();
    bit run;
    int nextMode;
    run = (mMode != 0) && pllLock && oscEnBit;
    nextMode = mMode;
    if (!oscEnBit) nextMode = 0;
    else if (mMode == 0) nextMode = 1;
    else if (mMode == 1 && !pllSelBit && mUp && pllLock) nextMode = 2;
    else if (mMode == 2 && pllSelBit) nextMode = 1;
    mLost = mUp && !run;
    if (mMode == 0) mDiv = refDiv;
    if (!run) begin
      mCnt = 0; mUp = 1'b0;
    end else if (qualTick) begin
      if (oscGood) begin
        if (mCnt < 4) mCnt++;
        if (mCnt == 4) mUp = 1'b1;
      end else begin
        mCnt = 0;
      end
    end
    mMode = nextMode;
  endtask

  task automatic step(string tag);
    modelEdge();
    @(posedge clk);
    #1;
    checkAll(tag);
  endtask

  task automatic goodTicks(int n, string tag);
    for (int i = 0; i < n; i++) begin
      qualTick = 1'b1; oscGood = 1'b1;
      step(tag);
    end
    qualTick = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    checkAll("R1");
    rstN = 1'b1;
    @(posedge clk); #1;
    checkAll("R1");

    // R11: divider follows while in default mode
    refDiv = 4'd5; step("R11");
    refDiv = 4'd9; step("R11");

    // R3: ticks in mode 0 do not count
    pllLock = 1'b1;
    goodTicks(5, "R3");

    // R2: enable oscillator -> mode 1
    oscEnBit = 1'b1; step("R2");

    // R11: divider frozen in external mode
    refDiv = 4'd3; step("R11");

    // R7: bypass request without oscUp ignored
    pllSelBit = 1'b0; step("R7"); step("R7");
    pllSelBit = 1'b1;

    // R4: bad tick restarts count
    goodTicks(3, "R4");
    qualTick = 1'b1; oscGood = 1'b0; step("R4");
    qualTick = 1'b0;
    goodTicks(3, "R4");
    chk("R4", "oscUp after restart", int'(oscUp), 0);
    goodTicks(1, "R3");
    chk("R3", "oscUp after 4 good", int'(oscUp), 1);

    // R6: bypass entry
    pllSelBit = 1'b0; step("R6");
    chk("R6", "busSelPll", int'(busSelPll), 0);

    // R5: lock loss drops flag combinationally
    pllLock = 1'b0; #1;
    checkAll("R5");
    chk("R5", "oscUp same cycle", int'(oscUp), 0);
    step("R10");
    chk("R10", "statusLost pulse", int'(statusLost), 1);
    step("R10");
    chk("R10", "statusLost one cycle", int'(statusLost), 0);

    // R8: back to engaged external
    pllLock = 1'b1;
    pllSelBit = 1'b1; step("R8");
    chk("R8", "mode", int'(modeOut), 1);

    // R9: disable oscillator after re-qualifying
    goodTicks(4, "R9");
    oscEnBit = 1'b0; step("R9");
    chk("R9", "mode", int'(modeOut), 0);
    chk("R10", "statusLost on disable", int'(statusLost), 1);
    step("R9");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      oscEnBit  = ($urandom_range(99) < 97);
      pllLock   = ($urandom_range(99) < 95);
      qualTick  = $urandom_range(1);
      oscGood   = ($urandom_range(99) < 85);
      if ($urandom_range(9) == 0) pllSelBit = ~pllSelBit;
      refDiv    = 4'($urandom_range(15));
      #1;
      checkAll("RAND");
      step("RAND");
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule